// File: doc/BRIEF.md
# One-Time Signature Authentication Gate

This block decides whether a memory tag may serve host traffic. The tag stores one or more sets of one-time private key material in an external key RAM. A host opens a session on one key set and then sends a series of challenge bits. For each bit the tag releases one of the two secrets held for that position and wipes both of them. When every position has been answered, the gate raises a sticky authenticated flag and marks the key set as used. Until the flag is up, the data segment behind the gate is shut off: reads return zeros and writes never reach the data memory.

The host reaches the gate through a small register-mapped bus with one request per cycle and read data one cycle later. A session that is abandoned or broken part-way leaves the flag clear, wipes the whole key set and marks it used, so no set can sign twice. A test-mode input gives access to the key RAM for loading and inspection, and allows the flag and the used markers to be cleared. With that input held low, the flag can never fall.

Top module: `otsauth_top`

## Requirements
- R1: While the authenticated flag is clear, every host read in the data region (h_addr[15:14]=01) returns 0 in the next cycle.
- R2: While the authenticated flag is clear, host writes in the data region never assert mem_en, so the data memory keeps its contents.
- R3: The flag (status bit 0, control register 3 in region 00) rises only when the response for the last challenge index (NUM_CHAL-1) is read. After that, data-region reads and writes are forwarded to the data memory.
- R4: A command write to register 0 with op 1 in bits [1:0] and set number in bits [8+]. It starts a session on that set. Each challenge bit written to register 1 (bit 0) selects the secret for (set, index, bit). The secret is then readable at register 2, and the index then advances by one.
- R5: Once a secret has been released, both secrets for that index read back as zero from the key RAM. Key word address = set*2*NUM_CHAL + index*2 + bit, with NUM_CHAL a power of two.
- R6: A session can end early in two ways: a command with op 2, or a challenge write when no challenge is awaited. Either way the flag stays clear, every word of the set is zeroed, and the set's used marker (status bit 16+set) is set.
- R7: A start command naming a set whose used marker is set is refused. Session-active status bit 1 stays 0.
- R8: After a completed exchange, every word of the used set reads back as zero and its used marker is set.
- R9: Each key set has its own marker. A burned set does not stop another, unused set from being used to authenticate.
- R10: Key-region accesses (h_addr[15:14]=10) work only with test_mode high; otherwise reads return 0. A command with op 3 clears the flag and all markers only with test_mode high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | Enables key access and flag clearing |
| h_req | input | 1 | Host request strobe |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 16 | Host address; [15:14] selects control, data or key region |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid with h_rvalid |
| h_rvalid | output | 1 | Read data valid, one cycle after a read request |
| mem_en | output | 1 | Data memory access enable |
| mem_we | output | 1 | Data memory write enable |
| mem_addr | output | 14 | Data memory word address |
| mem_wdata | output | 32 | Data memory write data |
| mem_rdata | input | 32 | Data memory read data, one cycle after mem_en |
| key_en | output | 1 | Key RAM access enable |
| key_we | output | 1 | Key RAM write enable |
| key_addr | output | 10 | Key RAM word address |
| key_wdata | output | 32 | Key RAM write data |
| key_rdata | input | 32 | Key RAM read data, one cycle after key_en |

## Verification
A flag that is set too early shows up at once. The next data read returns the stored word instead of zero, and mem_en pulses on a blocked write in the same cycle. A wrong challenge index or a wrong bit select shows up at the next response read as a secret that does not match the one expected for that position. A wipe that is missed or misaddressed stays hidden until the key words are read back in test mode. The bench therefore probes them both mid-session and after each session ends. Marker faults show up at the next start attempt, through status bit 1.

// File: rtl/otsauth_pkg.sv
// Shared encodings for the one-time signature authentication gate.
// Assumes the host address carries the region in its two top bits.
package otsauth_pkg;

    typedef enum logic [1:0] {
        RGN_CTRL = 2'd0,
        RGN_DATA = 2'd1,
        RGN_KEY  = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    localparam logic [1:0] REG_CMD  = 2'd0;
    localparam logic [1:0] REG_CHAL = 2'd1;
    localparam logic [1:0] REG_RESP = 2'd2;
    localparam logic [1:0] REG_STAT = 2'd3;

    localparam logic [1:0] OP_START = 2'd1;
    localparam logic [1:0] OP_ABORT = 2'd2;
    localparam logic [1:0] OP_TCLR  = 2'd3;

    typedef enum logic [2:0] {
        S_IDLE, S_WAITCH, S_FETCH, S_CAPT, S_CLR1, S_WAITRD, S_SWEEP
    } seq_e;

    typedef enum logic [1:0] {
        SRC_ZERO, SRC_REG, SRC_MEM, SRC_KEY
    } src_e;

endpackage

// File: rtl/otsauth_seq.sv
// Challenge sequencer: runs one session on one key set, releases and wipes
// secrets per index, raises the sticky flag at the end, and sweeps a set
// clean on abort. Assumes NUM_CHAL is a power of two and that the key RAM
// returns read data one cycle after the request.
module otsauth_seq
    import otsauth_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int NUM_CHAL = 256,
    parameter int DW       = 32,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int IDX_W   = $clog2(NUM_CHAL),
    localparam int KEY_AW  = SET_W + IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                test_mode,
    input  logic                cmd_wr,
    input  logic [1:0]          cmd_op,
    input  logic [SET_W-1:0]    cmd_set,
    input  logic                chal_wr,
    input  logic                chal_bit,
    input  logic                resp_rd,
    input  logic [DW-1:0]       key_rdata,
    output logic                authed,
    output logic [NUM_SETS-1:0] marks,
    output logic                active,
    output logic                resp_ready,
    output logic [DW-1:0]       resp_data,
    output logic                seq_own,
    output logic                seq_we,
    output logic [KEY_AW-1:0]   seq_addr
);

    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_CHAL - 1);
    localparam logic [IDX_W:0]   SWEEP_END = (IDX_W + 1)'(2 * NUM_CHAL - 1);

    seq_e                state_q;
    logic [SET_W-1:0]    set_q;
    logic [IDX_W-1:0]    idx_q;
    logic                bit_q;
    logic [DW-1:0]       resp_q;
    logic                authed_q;
    logic [NUM_SETS-1:0] mark_q;
    logic [IDX_W:0]      sweep_q;

    logic in_sess;
    logic start_ok;
    logic abort_req;

    // Session decode: which states count as an open exchange, and when it breaks.
    always_comb begin
        in_sess   = (state_q == S_WAITCH) || (state_q == S_FETCH) ||
                    (state_q == S_CAPT)   || (state_q == S_CLR1)  ||
                    (state_q == S_WAITRD);
        start_ok  = cmd_wr && (cmd_op == OP_START) &&
                    (int'(cmd_set) < NUM_SETS) && !mark_q[cmd_set];
        abort_req = in_sess && ((cmd_wr && (cmd_op == OP_ABORT)) ||
                                (chal_wr && (state_q != S_WAITCH)));
    end

    // Sequencer state, flag and marker updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            set_q    <= '0;
            idx_q    <= '0;
            bit_q    <= 1'b0;
            resp_q   <= '0;
            authed_q <= 1'b0;
            mark_q   <= '0;
            sweep_q  <= '0;
        end else if (state_q == S_IDLE) begin
            if (start_ok) begin
                set_q   <= cmd_set;
                idx_q   <= '0;
                state_q <= S_WAITCH;
            end else if (cmd_wr && (cmd_op == OP_TCLR) && test_mode) begin
                authed_q <= 1'b0;
                mark_q   <= '0;
            end
        end else if (abort_req) begin
            state_q <= S_SWEEP;
            sweep_q <= '0;
            resp_q  <= '0;
        end else begin
            case (state_q)
                S_WAITCH: if (chal_wr) begin
                    bit_q   <= chal_bit;
                    state_q <= S_FETCH;
                end
                S_FETCH: state_q <= S_CAPT;
                S_CAPT: begin
                    resp_q  <= key_rdata;
                    state_q <= S_CLR1;
                end
                S_CLR1: state_q <= S_WAITRD;
                S_WAITRD: if (resp_rd) begin
                    resp_q <= '0;
                    if (idx_q == LAST_IDX) begin
                        authed_q      <= 1'b1;
                        mark_q[set_q] <= 1'b1;
                        state_q       <= S_IDLE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= S_WAITCH;
                    end
                end
                S_SWEEP: begin
                    sweep_q <= sweep_q + 1'b1;
                    if (sweep_q == SWEEP_END) begin
                        mark_q[set_q] <= 1'b1;
                        state_q       <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Key RAM requests owned by the sequencer: fetch, two wipes, or sweep.
    always_comb begin
        seq_own  = 1'b0;
        seq_we   = 1'b0;
        seq_addr = {set_q, idx_q, bit_q};
        case (state_q)
            S_FETCH: seq_own = 1'b1;
            S_CAPT: begin
                seq_own  = 1'b1;
                seq_we   = 1'b1;
                seq_addr = {set_q, idx_q, 1'b0};
            end
            S_CLR1: begin
                seq_own  = 1'b1;
                seq_we   = 1'b1;
                seq_addr = {set_q, idx_q, 1'b1};
            end
            S_SWEEP: begin
                seq_own  = 1'b1;
                seq_we   = 1'b1;
                seq_addr = {set_q, sweep_q};
            end
            default: ;
        endcase
    end

    assign authed     = authed_q;
    assign marks      = mark_q;
    assign active     = (state_q != S_IDLE);
    assign resp_ready = (state_q == S_WAITRD);
    assign resp_data  = resp_q;

    // Flag can only fall through the test-mode clear.
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (authed_q && !test_mode) |=> authed_q);

    // A used marker never clears outside test mode.
    p_mark_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> ((mark_q & $past(mark_q)) == $past(mark_q)));

    // Flag rises only on the final response read.
    p_auth_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(authed_q) |-> ($past(state_q) == S_WAITRD && $past(idx_q) == LAST_IDX));

    // After a fetch the captured secret is followed by wiping both halves.
    p_wipe_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CAPT && !abort_req) |=> (state_q == S_CLR1 && seq_we));

endmodule

// File: rtl/otsauth_keyport.sv
// Key RAM port arbiter: the sequencer owns the port while it fetches or
// wipes; otherwise the host may reach the key RAM, but only in test mode.
// Assumes one access per cycle on the key RAM.
module otsauth_keyport #(
    parameter int DW     = 32,
    parameter int KEY_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode,
    input  logic              seq_own,
    input  logic              seq_we,
    input  logic [KEY_AW-1:0] seq_addr,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [KEY_AW-1:0] host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic              host_gnt,
    output logic              key_en,
    output logic              key_we,
    output logic [KEY_AW-1:0] key_addr,
    output logic [DW-1:0]     key_wdata
);

    // Port mux: sequencer first, test-mode host second.
    always_comb begin
        host_gnt  = host_req && test_mode && !seq_own;
        key_en    = seq_own || host_gnt;
        key_we    = seq_own ? seq_we : (host_gnt && host_we);
        key_addr  = seq_own ? seq_addr : host_addr;
        key_wdata = seq_own ? '0 : host_wdata;
    end

    // Non-zero key material is written only under test mode.
    p_key_write_test_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (key_en && key_we && (key_wdata != '0)) |-> test_mode);

endmodule

// File: rtl/otsauth_gate.sv
// Host access gate: decodes the region and control registers, blocks the
// data segment until the flag is set, and returns read data one cycle
// after each read request. Assumes DW >= 16 + NUM_SETS for the status word.
module otsauth_gate
    import otsauth_pkg::*;
#(
    parameter int HAW      = 16,
    parameter int DW       = 32,
    parameter int NUM_SETS = 2,
    parameter int SET_W    = 1,
    parameter int KEY_AW   = 10,
    localparam int DATA_AW = HAW - 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                h_req,
    input  logic                h_we,
    input  logic [HAW-1:0]      h_addr,
    input  logic [DW-1:0]       h_wdata,
    output logic [DW-1:0]       h_rdata,
    output logic                h_rvalid,
    input  logic                authed,
    input  logic [NUM_SETS-1:0] marks,
    input  logic                active,
    input  logic                resp_ready,
    input  logic [DW-1:0]       resp_data,
    output logic                cmd_wr,
    output logic [1:0]          cmd_op,
    output logic [SET_W-1:0]    cmd_set,
    output logic                chal_wr,
    output logic                chal_bit,
    output logic                resp_rd,
    output logic                host_key_req,
    output logic [KEY_AW-1:0]   host_key_addr,
    input  logic                host_gnt,
    output logic                mem_en,
    output logic                mem_we,
    output logic [DATA_AW-1:0]  mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic [DW-1:0]       mem_rdata,
    input  logic [DW-1:0]       key_rdata
);

    region_e      rgn;
    logic         ctrl_hit;
    logic [1:0]   off;
    logic [DW-1:0] stat;
    logic [DW-1:0] reg_val;
    src_e         src_d;
    src_e         src_q;
    logic [DW-1:0] regv_q;
    logic         rvalid_q;

    // Region and register decode; control hits need the spare bits at zero.
    always_comb begin
        rgn      = region_e'(h_addr[HAW-1 -: 2]);
        off      = h_addr[1:0];
        ctrl_hit = h_req && (rgn == RGN_CTRL) && (h_addr[HAW-3:2] == '0);
        cmd_wr   = ctrl_hit && h_we && (off == REG_CMD);
        chal_wr  = ctrl_hit && h_we && (off == REG_CHAL);
        resp_rd  = ctrl_hit && !h_we && (off == REG_RESP) && resp_ready;
        cmd_op   = h_wdata[1:0];
        cmd_set  = h_wdata[8 +: SET_W];
        chal_bit = h_wdata[0];
    end

    // Data segment forwarding, only once the flag is set.
    always_comb begin
        mem_en    = h_req && (rgn == RGN_DATA) && authed;
        mem_we    = h_we;
        mem_addr  = h_addr[DATA_AW-1:0];
        mem_wdata = h_wdata;
    end

    assign host_key_req  = h_req && (rgn == RGN_KEY);
    assign host_key_addr = h_addr[KEY_AW-1:0];

    // Status word and control-register read value.
    always_comb begin
        stat    = '0;
        stat[0] = authed;
        stat[1] = active;
        stat[2] = resp_ready;
        for (int s = 0; s < NUM_SETS; s++) stat[16 + s] = marks[s];
        reg_val = '0;
        if (ctrl_hit && off == REG_STAT)               reg_val = stat;
        else if (ctrl_hit && off == REG_RESP && resp_ready) reg_val = resp_data;
    end

    // Select the source of the next cycle's read data.
    always_comb begin
        src_d = SRC_ZERO;
        if (rgn == RGN_DATA && authed)     src_d = SRC_MEM;
        else if (rgn == RGN_KEY && host_gnt) src_d = SRC_KEY;
        else if (ctrl_hit)                 src_d = SRC_REG;
    end

    // Read-response pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            src_q    <= SRC_ZERO;
            regv_q   <= '0;
        end else begin
            rvalid_q <= h_req && !h_we;
            src_q    <= src_d;
            regv_q   <= reg_val;
        end
    end

    // Read data mux.
    always_comb begin
        case (src_q)
            SRC_MEM: h_rdata = mem_rdata;
            SRC_KEY: h_rdata = key_rdata;
            SRC_REG: h_rdata = regv_q;
            default: h_rdata = '0;
        endcase
    end
    assign h_rvalid = rvalid_q;

    // No data memory traffic while the gate is closed.
    p_gate_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !authed |-> !mem_en);

    // A blocked data read answers with zeros in the next cycle.
    p_zero_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && !h_we && rgn == RGN_DATA && !authed) |=> (h_rvalid && h_rdata == '0));

endmodule

// File: rtl/otsauth_top.sv
// Top of the authentication gate: host gate, challenge sequencer and key
// port arbiter. Assumes external data and key RAMs with one-cycle reads.
module otsauth_top #(
    parameter int NUM_SETS = 2,
    parameter int NUM_CHAL = 256,
    parameter int DW       = 32,
    parameter int HAW      = 16,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int IDX_W   = $clog2(NUM_CHAL),
    localparam int KEY_AW  = SET_W + IDX_W + 1,
    localparam int DATA_AW = HAW - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               test_mode,
    input  logic               h_req,
    input  logic               h_we,
    input  logic [HAW-1:0]     h_addr,
    input  logic [DW-1:0]      h_wdata,
    output logic [DW-1:0]      h_rdata,
    output logic               h_rvalid,
    output logic               mem_en,
    output logic               mem_we,
    output logic [DATA_AW-1:0] mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    output logic               key_en,
    output logic               key_we,
    output logic [KEY_AW-1:0]  key_addr,
    output logic [DW-1:0]      key_wdata,
    input  logic [DW-1:0]      key_rdata
);

    logic                authed;
    logic [NUM_SETS-1:0] marks;
    logic                active;
    logic                resp_ready;
    logic [DW-1:0]       resp_data;
    logic                cmd_wr;
    logic [1:0]          cmd_op;
    logic [SET_W-1:0]    cmd_set;
    logic                chal_wr;
    logic                chal_bit;
    logic                resp_rd;
    logic                host_key_req;
    logic [KEY_AW-1:0]   host_key_addr;
    logic                host_gnt;
    logic                seq_own;
    logic                seq_we;
    logic [KEY_AW-1:0]   seq_addr;

    otsauth_gate #(
        .HAW(HAW), .DW(DW), .NUM_SETS(NUM_SETS), .SET_W(SET_W), .KEY_AW(KEY_AW)
    ) u_gate (
        .clk(clk), .rst_n(rst_n),
        .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_rvalid(h_rvalid),
        .authed(authed), .marks(marks), .active(active),
        .resp_ready(resp_ready), .resp_data(resp_data),
        .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_set(cmd_set),
        .chal_wr(chal_wr), .chal_bit(chal_bit), .resp_rd(resp_rd),
        .host_key_req(host_key_req), .host_key_addr(host_key_addr),
        .host_gnt(host_gnt),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .key_rdata(key_rdata)
    );

    otsauth_seq #(
        .NUM_SETS(NUM_SETS), .NUM_CHAL(NUM_CHAL), .DW(DW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
        .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_set(cmd_set),
        .chal_wr(chal_wr), .chal_bit(chal_bit), .resp_rd(resp_rd),
        .key_rdata(key_rdata),
        .authed(authed), .marks(marks), .active(active),
        .resp_ready(resp_ready), .resp_data(resp_data),
        .seq_own(seq_own), .seq_we(seq_we), .seq_addr(seq_addr)
    );

    otsauth_keyport #(
        .DW(DW), .KEY_AW(KEY_AW)
    ) u_keyport (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
        .seq_own(seq_own), .seq_we(seq_we), .seq_addr(seq_addr),
        .host_req(host_key_req), .host_we(h_we), .host_addr(host_key_addr),
        .host_wdata(h_wdata), .host_gnt(host_gnt),
        .key_en(key_en), .key_we(key_we), .key_addr(key_addr),
        .key_wdata(key_wdata)
    );

endmodule

// File: tb/tb_otsauth_top.sv
// Scoreboard bench: driver tasks queue expected read data, a monitor pops
// and compares each returned word.
module tb_otsauth_top;

    localparam logic [15:0] A_CMD  = 16'h0000;
    localparam logic [15:0] A_CHAL = 16'h0001;
    localparam logic [15:0] A_RESP = 16'h0002;
    localparam logic [15:0] A_STAT = 16'h0003;
    localparam logic [15:0] A_DATA = 16'h4000;
    localparam logic [15:0] A_KEY  = 16'h8000;
    localparam int NCH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        test_mode = 1'b0;
    logic        h_req = 1'b0;
    logic        h_we = 1'b0;
    logic [15:0] h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        h_rvalid;
    logic        mem_en, mem_we;
    logic [13:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        key_en, key_we;
    logic [9:0]  key_addr;
    logic [31:0] key_wdata;
    logic [31:0] key_rdata = '0;

    int checks = 0;
    int errors = 0;
    int blocked_mem = 0;
    bit gate_open = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    logic [31:0] dmem [0:16383];
    logic [31:0] kmem [0:1023];

    always #4 clk = ~clk;

    otsauth_top dut (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
        .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_rvalid(h_rvalid),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .key_en(key_en), .key_we(key_we), .key_addr(key_addr),
        .key_wdata(key_wdata), .key_rdata(key_rdata)
    );

    // Data and key RAM models with one-cycle reads.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) dmem[mem_addr] <= mem_wdata;
            else        mem_rdata <= dmem[mem_addr];
        end
        if (key_en) begin
            if (key_we) kmem[key_addr] <= key_wdata;
            else        key_rdata <= kmem[key_addr];
        end
        if (mem_en && !gate_open) blocked_mem++;
    end

    function automatic logic [31:0] sec(int s, int i, int b);
        return 32'hC300_0001 ^ (s << 20) ^ (i << 4) ^ (b << 1);
    endfunction

    function automatic logic [15:0] kaddr(int s, int i, int b);
        return A_KEY | 16'(s * 2 * NCH + i * 2 + b);
    endfunction

    function automatic bit cbit(int i);
        return bit'((i ^ (i >> 3)) & 1);
    endfunction

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare every returned read word against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && h_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL unexpected read actual=%h expected=none", h_rdata);
            end else begin
                chk(h_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic bus_wr(logic [15:0] a, logic [31:0] d);
        h_req = 1'b1; h_we = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_req = 1'b0; h_we = 1'b0;
    endtask

    task automatic bus_rd(logic [15:0] a, logic [31:0] exp, string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        h_req = 1'b1; h_we = 1'b0; h_addr = a;
        @(negedge clk);
        h_req = 1'b0;
    endtask

    task automatic challenge(int s, int i, string tag);
        bus_wr(A_CHAL, 32'(cbit(i)));
        repeat (5) @(negedge clk);
        bus_rd(A_RESP, sec(s, i, int'(cbit(i))), tag);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        for (int a = 0; a < 16384; a++) dmem[a] = '0;
        for (int a = 0; a < 1024; a++) kmem[a] = '0;
        dmem[5] = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk({31'd0, h_rvalid}, 32'd0, "reset rvalid");
        chk({30'd0, mem_en, key_en}, 32'd0, "reset port enables");
        bus_rd(A_STAT, 32'h0, "reset status");

        // R10: load both key sets in test mode, then read one back
        test_mode = 1'b1;
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < NCH; i++)
                for (int b = 0; b < 2; b++)
                    bus_wr(kaddr(s, i, b), sec(s, i, b));
        bus_rd(kaddr(1, 7, 1), sec(1, 7, 1), "R10 test-mode key read");
        test_mode = 1'b0;
        bus_rd(kaddr(1, 7, 1), 32'h0, "R10 key read without test mode");

        // R1/R2: data segment closed
        bus_wr(A_DATA | 16'd5, 32'hDEAD_BEEF);
        bus_rd(A_DATA | 16'd5, 32'h0, "R1 blocked data read");

        // R6: abandon a session on set 1 with an out-of-order challenge
        bus_wr(A_CMD, 32'h0000_0101);
        bus_rd(A_STAT, 32'h0000_0002, "R4 session active");
        challenge(1, 0, "R4 set1 idx0");
        challenge(1, 1, "R4 set1 idx1");
        bus_wr(A_CHAL, 32'd0);
        bus_wr(A_CHAL, 32'd1);
        repeat (600) @(negedge clk);
        bus_rd(A_STAT, 32'h0002_0000, "R6 aborted: flag clear, set1 marked");
        bus_rd(A_DATA | 16'd5, 32'h0, "R6 data still blocked");
        test_mode = 1'b1;
        bus_rd(kaddr(1, 5, 0), 32'h0, "R6 unused word swept");
        bus_rd(kaddr(1, 255, 1), 32'h0, "R6 last word swept");
        test_mode = 1'b0;

        // R7: burned set cannot be restarted
        bus_wr(A_CMD, 32'h0000_0101);
        bus_rd(A_STAT, 32'h0002_0000, "R7 start on used set refused");

        // R9/R4/R5: full exchange on set 0
        bus_wr(A_CMD, 32'h0000_0001);
        bus_rd(A_STAT, 32'h0002_0002, "R9 unused set still starts");
        for (int i = 0; i < NCH; i++) begin
            challenge(0, i, "R4 response");
            if (i == 10) begin
                test_mode = 1'b1;
                bus_rd(kaddr(0, 10, 0), 32'h0, "R5 released idx bit0 wiped");
                bus_rd(kaddr(0, 10, 1), 32'h0, "R5 released idx bit1 wiped");
                bus_rd(kaddr(0, 11, 0), sec(0, 11, 0), "R5 next idx intact");
                test_mode = 1'b0;
            end
            if (i == 100) bus_rd(A_DATA | 16'd5, 32'h0, "R1 mid-session data read");
        end
        gate_open = 1'b1;
        bus_rd(A_STAT, 32'h0003_0001, "R3 flag set, R8 set0 marked");

        // R2/R3: data forwarded, earlier blocked write left no trace
        bus_rd(A_DATA | 16'd5, 32'h1234_5678, "R2 blocked write had no effect");
        bus_wr(A_DATA | 16'd9, 32'hCAFE_0001);
        bus_rd(A_DATA | 16'd9, 32'hCAFE_0001, "R3 forwarded write/read");

        // R8: used set reads back as zeros
        test_mode = 1'b1;
        bus_rd(kaddr(0, 0, 0), 32'h0, "R8 set0 word wiped");
        bus_rd(kaddr(0, 200, 1), 32'h0, "R8 set0 word wiped");
        test_mode = 1'b0;
        bus_wr(A_CMD, 32'h0000_0001);
        bus_rd(A_STAT, 32'h0003_0001, "R7 completed set refused");

        // R10: clear only under test mode
        bus_wr(A_CMD, 32'h0000_0003);
        bus_rd(A_STAT, 32'h0003_0001, "R10 clear ignored without test mode");
        test_mode = 1'b1;
        bus_wr(A_CMD, 32'h0000_0003);
        bus_rd(A_STAT, 32'h0000_0000, "R10 clear with test mode");
        test_mode = 1'b0;
        gate_open = 1'b0;
        bus_rd(A_DATA | 16'd9, 32'h0, "R1 closed again after clear");

        repeat (4) @(negedge clk);
        chk(32'(blocked_mem), 32'd0, "R2 mem_en while closed");
        chk(32'(exp_q.size()), 32'd0, "scoreboard drained");
        summary();
        $finish;
    end

endmodule